// File: doc/BRIEF.md
# Control Response Rate Selector

This block picks the transmit rate for a control response (an ACK or a CTS, say) that answers a frame received at a known rate. It takes the basic-rate bitmap of the network, the index of the received rate and a band flag. It returns the response rate index, together with the 8-bit signal code and the 8-bit reserve time that belong to that rate in the selected band.

A request strobe samples the inputs. The result and a valid flag appear in registers one clock later. The result stays unchanged until the next strobe. Received rates in the low-rate class and in the multi-carrier class fall back by different rules. When no lower basic rate qualifies, the fallback for the multi-carrier class is the 24 Mb/s index.

Top module: `resp_rate_sel`

## Requirements
- R1: Rate index encoding: 0..3 are 1, 2, 5.5 and 11 Mb/s (CCK class); 4..11 are 6, 9, 12, 18, 24, 36, 48 and 54 Mb/s (OFDM class). Bit i of the basic-rate bitmap marks index i as basic. A received index above 11 is handled as index 11.
- R2: For a received index r of 0..3, the response rate is the highest index i with 1 <= i <= r whose basic bit is set, or index 0 if there is none.
- R3: For a received OFDM index when bitmap bits 4..11 are all clear, the response rate is the received index limited to at most 8.
- R4: For a received index of 4..8, the response rate equals the received index, whatever the bitmap holds.
- R5: For a received index of 9..11 with at least one of bitmap bits 4..11 set, the response rate is the highest set index i with 4 <= i <= r. If no such index exists, it is 8.
- R6: With band_5g_i=1 the signal code for indices 4..11 is 0x9B, 0x9F, 0x9A, 0x9E, 0x99, 0x9D, 0x98, 0x9C, and the reserve time is 44, 36, 32, 28, 28, 24, 24, 24.
- R7: With band_5g_i=0 the signal code is the R6 code with bit 4 cleared, and the reserve time is the R6 value plus 6.
- R8: A response rate in 0..3 is reported with the code and reserve time of index 8 for the selected band.
- R9: A strobe on req_i at a clock edge produces the new outputs, and valid_o=1, at that same edge. There is no combinational path from the inputs to the outputs.
- R10: Without req_i, resp_rate_o, sig_code_o, rsv_time_o and valid_o keep their values.
- R11: Reset (rst_ni=0, asynchronous) clears all outputs and valid_o to 0. They stay 0 until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; samples the inputs |
| basic_rates_i | input | 12 | Basic-rate bitmap, bit i = rate index i |
| rx_rate_i | input | 4 | Received rate index |
| band_5g_i | input | 1 | 1 = 5 GHz tables, 0 = 2.4 GHz tables |
| valid_o | output | 1 | Outputs hold a result |
| resp_rate_o | output | 4 | Chosen response rate index |
| sig_code_o | output | 8 | Signal code of the response rate |
| rsv_time_o | output | 8 | Reserve time of the response rate |

## Verification
The block has no state beyond its output registers. A wrong search result or a wrong table entry is therefore visible one edge after the strobe that caused it, on resp_rate_o or on the code and reserve outputs. The bench runs bitmaps that place basic bits above, at and below the received index, along with bitmaps with no OFDM bits at all. The fallback boundaries at indices 1, 8 and 11 each have a check. A register that loads without a strobe, or that misses one, shows up as a change between strobes or as a stale value right after the strobe. The bench looks for both.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int unsigned NUM_RATES = 12;
  localparam int unsigned NUM_CCK   = 4;
  localparam int unsigned NUM_OFDM  = NUM_RATES - NUM_CCK;
  localparam int unsigned RATE_W    = $clog2(NUM_RATES);
  localparam int unsigned FB_IDX    = 8;   // 24 Mb/s fallback index
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned RSV_W     = 8;
  localparam int unsigned BAND_DLT  = 6;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [CODE_W-1:0] code;
    logic [RSV_W-1:0]  rsv;
  } resp_t;
endpackage

// File: rtl/rrs_cck_search.sv
module rrs_cck_search #(
  parameter int unsigned N_CCK = 4,
  parameter int unsigned W     = 4
) (
  input  logic [N_CCK-1:0] basic_i,
  input  logic [W-1:0]     start_i,
  output logic [W-1:0]     rate_o
);
  // ascending scan: the last hit is the highest set index <= start; none -> 0
  always_comb begin
    rate_o = '0;
    for (int i = 0; i < N_CCK; i++) begin
      if (basic_i[i] && (W'(i) <= start_i)) rate_o = W'(i);
    end
  end
endmodule

// File: rtl/rrs_ofdm_search.sv
module rrs_ofdm_search #(
  parameter int unsigned N_OFDM = 8,
  parameter int unsigned BASE   = 4,
  parameter int unsigned FB     = 8,
  parameter int unsigned W      = 4
) (
  input  logic [N_OFDM-1:0] basic_i,
  input  logic [W-1:0]      start_i,
  output logic [W-1:0]      rate_o
);
  localparam logic [W-1:0] FB_W = W'(FB);

  logic any_basic;
  assign any_basic = |basic_i;

  always_comb begin
    if (!any_basic || (start_i <= FB_W)) begin
      rate_o = (start_i > FB_W) ? FB_W : start_i;
    end else begin
      rate_o = FB_W;
      for (int i = 0; i < N_OFDM; i++) begin
        if (basic_i[i] && (W'(BASE + i) <= start_i)) rate_o = W'(BASE + i);
      end
    end
  end
endmodule

// File: rtl/rrs_phy_map.sv
module rrs_phy_map #(
  parameter int unsigned W     = 4,
  parameter int unsigned CW    = 8,
  parameter int unsigned RW    = 8,
  parameter int unsigned DELTA = 6
) (
  input  logic [W-1:0]  rate_i,
  input  logic          band_5g_i,
  output logic [CW-1:0] code_o,
  output logic [RW-1:0] rsv_o
);
  logic [CW-1:0] code_5g;
  logic [RW-1:0] rsv_5g;

  always_comb begin
    unique case (rate_i)
      W'(4):   begin code_5g = CW'(8'h9B); rsv_5g = RW'(44); end
      W'(5):   begin code_5g = CW'(8'h9F); rsv_5g = RW'(36); end
      W'(6):   begin code_5g = CW'(8'h9A); rsv_5g = RW'(32); end
      W'(7):   begin code_5g = CW'(8'h9E); rsv_5g = RW'(28); end
      W'(9):   begin code_5g = CW'(8'h9D); rsv_5g = RW'(24); end
      W'(10):  begin code_5g = CW'(8'h98); rsv_5g = RW'(24); end
      W'(11):  begin code_5g = CW'(8'h9C); rsv_5g = RW'(24); end
      default: begin code_5g = CW'(8'h99); rsv_5g = RW'(28); end  // 24M and non-OFDM
    endcase
  end

  always_comb begin
    code_o = code_5g;
    rsv_o  = rsv_5g;
    if (!band_5g_i) begin
      code_o[4] = 1'b0;
      rsv_o     = rsv_5g + RW'(DELTA);
    end
  end
endmodule

// File: rtl/resp_rate_sel.sv
module resp_rate_sel
  import rrs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [NUM_RATES-1:0] basic_rates_i,
  input  logic [RATE_W-1:0]    rx_rate_i,
  input  logic                 band_5g_i,
  output logic                 valid_o,
  output logic [RATE_W-1:0]    resp_rate_o,
  output logic [CODE_W-1:0]    sig_code_o,
  output logic [RSV_W-1:0]     rsv_time_o
);
  localparam logic [RATE_W-1:0] TOP_IDX = RATE_W'(NUM_RATES - 1);

  logic [RATE_W-1:0] rx_eff, cck_rate, ofdm_rate;
  logic              is_cck;
  resp_t             nxt_q, nxt_d;

  assign rx_eff = (rx_rate_i > TOP_IDX) ? TOP_IDX : rx_rate_i;
  assign is_cck = rx_eff < RATE_W'(NUM_CCK);

  rrs_cck_search #(.N_CCK(NUM_CCK), .W(RATE_W)) u_cck (
    .basic_i (basic_rates_i[NUM_CCK-1:0]),
    .start_i (rx_eff),
    .rate_o  (cck_rate)
  );

  rrs_ofdm_search #(.N_OFDM(NUM_OFDM), .BASE(NUM_CCK), .FB(FB_IDX), .W(RATE_W)) u_ofdm (
    .basic_i (basic_rates_i[NUM_RATES-1:NUM_CCK]),
    .start_i (rx_eff),
    .rate_o  (ofdm_rate)
  );

  assign nxt_d.rate = is_cck ? cck_rate : ofdm_rate;

  rrs_phy_map #(.W(RATE_W), .CW(CODE_W), .RW(RSV_W), .DELTA(BAND_DLT)) u_map (
    .rate_i    (nxt_d.rate),
    .band_5g_i (band_5g_i),
    .code_o    (nxt_d.code),
    .rsv_o     (nxt_d.rsv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q   <= '0;
      valid_o <= 1'b0;
    end else if (req_i) begin
      nxt_q   <= nxt_d;
      valid_o <= 1'b1;
    end
  end

  assign resp_rate_o = nxt_q.rate;
  assign sig_code_o  = nxt_q.code;
  assign rsv_time_o  = nxt_q.rsv;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int unsigned NR = 12,
  parameter int unsigned NC = 4,
  parameter int unsigned FB = 8,
  parameter int unsigned W  = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [NR-1:0] basic_rates_i,
  input logic [W-1:0]  rx_rate_i,
  input logic          band_5g_i,
  input logic          valid_o,
  input logic [W-1:0]  resp_rate_o,
  input logic [7:0]    sig_code_o,
  input logic [7:0]    rsv_time_o
);
  assert_req_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);

  assert_valid_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(resp_rate_o) && $stable(sig_code_o) && $stable(rsv_time_o)));

  assert_idle_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (resp_rate_o == '0 && sig_code_o == '0 && rsv_time_o == '0));

  assert_band_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (sig_code_o[4] == $past(band_5g_i)));

  assert_cck_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rx_rate_i < W'(NC)) |=> (resp_rate_o <= $past(rx_rate_i)));

  assert_cck_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rx_rate_i < W'(NC)) |=> (sig_code_o[3:0] == 4'h9));

  assert_direct_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rx_rate_i >= W'(NC) && rx_rate_i <= W'(FB)) |=> (resp_rate_o == $past(rx_rate_i)));

  assert_ofdm_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rx_rate_i >= W'(NC)) |=> (resp_rate_o >= W'(NC) && resp_rate_o <= W'(NR - 1)));
endmodule

bind resp_rate_sel rrs_checker #(
  .NR(rrs_pkg::NUM_RATES), .NC(rrs_pkg::NUM_CCK), .FB(rrs_pkg::FB_IDX), .W(rrs_pkg::RATE_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .basic_rates_i (basic_rates_i),
  .rx_rate_i     (rx_rate_i),
  .band_5g_i     (band_5g_i),
  .valid_o       (valid_o),
  .resp_rate_o   (resp_rate_o),
  .sig_code_o    (sig_code_o),
  .rsv_time_o    (rsv_time_o)
);

// File: tb/resp_rate_sel_tb.sv
module resp_rate_sel_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [11:0] basic_rates_i = '0;
  logic [3:0]  rx_rate_i = '0;
  logic        band_5g_i = 1'b0;
  logic        valid_o;
  logic [3:0]  resp_rate_o;
  logic [7:0]  sig_code_o;
  logic [7:0]  rsv_time_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5ns clk_i = ~clk_i;

  resp_rate_sel u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .basic_rates_i(basic_rates_i),
    .rx_rate_i(rx_rate_i), .band_5g_i(band_5g_i), .valid_o(valid_o),
    .resp_rate_o(resp_rate_o), .sig_code_o(sig_code_o), .rsv_time_o(rsv_time_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  function automatic int exp_rate(input logic [11:0] b, input int rx);
    int r = (rx > 11) ? 11 : rx;
    if (r < 4) begin
      for (int i = r; i >= 1; i--) if (b[i]) return i;
      return 0;
    end
    if (r <= 8) return r;
    if (b[11:4] == 8'h00) return 8;
    for (int i = r; i >= 4; i--) if (b[i]) return i;
    return 8;
  endfunction

  function automatic int exp_code(input int r, input bit b5);
    int c;
    case (r)
      4: c = 'h9B; 5: c = 'h9F; 6: c = 'h9A; 7: c = 'h9E;
      9: c = 'h9D; 10: c = 'h98; 11: c = 'h9C;
      default: c = 'h99;
    endcase
    return b5 ? c : (c & 'hEF);
  endfunction

  function automatic int exp_rsv(input int r, input bit b5);
    int t;
    case (r)
      4: t = 44; 5: t = 36; 6: t = 32; 7: t = 28;
      9, 10, 11: t = 24;
      default: t = 28;
    endcase
    return b5 ? t : t + 6;
  endfunction

  // strobe at a falling edge, captured at the next rising edge, sampled at the next falling edge
  task automatic issue(input logic [11:0] b, input logic [3:0] rx, input bit b5);
    @(negedge clk_i);
    basic_rates_i = b; rx_rate_i = rx; band_5g_i = b5; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic issue_chk(input string tag, input logic [11:0] b, input logic [3:0] rx, input bit b5);
    int r;
    issue(b, rx, b5);
    r = exp_rate(b, int'(rx));
    chk({tag, " rate"}, int'(resp_rate_o), r);
    chk({tag, " code"}, int'(sig_code_o), exp_code(r, b5));
    chk({tag, " rsv"},  int'(rsv_time_o), exp_rsv(r, b5));
    chk({tag, " valid"}, int'(valid_o), 1);
  endtask

  task automatic t_reset();
    #1ns;
    chk("R11 valid in reset", int'(valid_o), 0);
    chk("R11 rate in reset", int'(resp_rate_o), 0);
    chk("R11 code in reset", int'(sig_code_o), 0);
    chk("R11 rsv in reset", int'(rsv_time_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R11 valid idle after reset", int'(valid_o), 0);
    chk("R11 rate idle after reset", int'(resp_rate_o), 0);
  endtask

  task automatic t_cck();
    issue_chk("R2 cck bits0,2 rx3", 12'h005, 4'd3, 1'b1);
    chk("R2 rx3 picks 2", int'(resp_rate_o), 2);
    issue_chk("R2 cck rx1 no bit1", 12'h005, 4'd1, 1'b0);
    chk("R2 rx1 falls to 0", int'(resp_rate_o), 0);
    issue_chk("R2 cck bit3 rx3", 12'h008, 4'd3, 1'b1);
    issue_chk("R2 cck empty rx2", 12'h000, 4'd2, 1'b1);
    issue_chk("R2 cck ofdm-only rx3", 12'hFF0, 4'd3, 1'b0);
    chk("R8 cck code 2.4G", int'(sig_code_o), 'h89);
    chk("R8 cck rsv 2.4G", int'(rsv_time_o), 34);
  endtask

  task automatic t_no_ofdm();
    issue_chk("R3 no ofdm rx11", 12'h00F, 4'd11, 1'b1);
    chk("R3 clamp to 8", int'(resp_rate_o), 8);
    issue_chk("R3 no ofdm rx9", 12'h003, 4'd9, 1'b0);
    issue_chk("R3 no ofdm rx6", 12'h00F, 4'd6, 1'b1);
  endtask

  task automatic t_direct();
    issue_chk("R4 rx5 with 54M basic", 12'h800, 4'd5, 1'b1);
    chk("R4 rx5 direct", int'(resp_rate_o), 5);
    issue_chk("R4 rx8 with 6M basic", 12'h010, 4'd8, 1'b0);
    issue_chk("R4 rx4 with 54M basic", 12'h800, 4'd4, 1'b1);
  endtask

  task automatic t_search();
    issue_chk("R5 bits5,7 rx11", 12'h0A0, 4'd11, 1'b1);
    chk("R5 picks 7", int'(resp_rate_o), 7);
    issue_chk("R5 only 54M rx10", 12'h800, 4'd10, 1'b1);
    chk("R5 none below -> 8", int'(resp_rate_o), 8);
    issue_chk("R5 bit10 rx10", 12'h400, 4'd10, 1'b0);
    issue_chk("R5 bit9 rx11", 12'h200, 4'd11, 1'b1);
    issue_chk("R1 rx15 as 11", 12'h200, 4'd15, 1'b1);
    chk("R1 rx15 picks 9", int'(resp_rate_o), 9);
    issue_chk("R1 rx12 all basic", 12'hFFF, 4'd12, 1'b0);
  endtask

  task automatic t_tables();
    for (int r = 4; r <= 11; r++) begin
      issue_chk($sformatf("R6 5G idx%0d", r), 12'hFF0, 4'(r), 1'b1);
      issue_chk($sformatf("R7 2.4G idx%0d", r), 12'hFF0, 4'(r), 1'b0);
    end
  endtask

  task automatic t_latency();
    issue(12'h0A0, 4'd11, 1'b1);  // result is 7
    @(negedge clk_i);
    basic_rates_i = 12'hFFF; rx_rate_i = 4'd4; band_5g_i = 1'b0; req_i = 1'b1;
    #1ns;
    chk("R9 no comb path rate", int'(resp_rate_o), 7);
    chk("R9 no comb path code", int'(sig_code_o), 'h9E);
    @(posedge clk_i);
    #1ns;
    req_i = 1'b0;
    chk("R9 rate one edge later", int'(resp_rate_o), 4);
    chk("R9 code one edge later", int'(sig_code_o), 'h8B);
    chk("R9 valid", int'(valid_o), 1);
  endtask

  task automatic t_hold();
    issue(12'h0A0, 4'd11, 1'b1);
    basic_rates_i = 12'h000; rx_rate_i = 4'd2; band_5g_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R10 rate held", int'(resp_rate_o), 7);
    chk("R10 code held", int'(sig_code_o), 'h9E);
    chk("R10 rsv held", int'(rsv_time_o), 28);
    chk("R10 valid held", int'(valid_o), 1);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cck();
    t_no_ofdm();
    t_direct();
    t_search();
    t_tables();
    t_latency();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule